// File: doc/BRIEF.md
# Reconfigurable Unit Configuration Controller

This block couples a small 16-bit processor core to a reconfigurable functional unit. The core works in three phases. The first phase loads a configuration, the second computes, and the third writes the result back. This block handles all three. A configure request carries a configuration number. The controller reads the matching bitstream from a configuration cache, one bit per address, and shifts it serially into the array. While it shifts, a configuration enable is held high. The core gets an acknowledge only when the last bit has gone in.

A compute request places the two 16-bit operand registers on a fixed set of array input pads. The controller then counts a programmable latency and raises a done flag. A write-back request copies the array's fixed output pads into the result register. The controller refuses to compute before a configuration has been loaded, and it reports that case. While a load is running it turns away further configure requests.

Top module: `rfu_cfg_ctrl`

## Requirements
- R1: After reset `set_busy`, `set_ack`, `cfg_en`, `exec_done`, `exec_err` and `res_valid` are 0, `res_out` is 0, and no configuration is valid.
- R2: A `set_req` accepted while idle sets `set_busy` on the next cycle. The cache is then read with `cache_idx` equal to the requested index and `cache_addr` stepping 0, 1, ..., BS_LEN-1, one address per cycle.
- R3: `cfg_en` is high for exactly BS_LEN consecutive cycles per load. The k-th bit presented on `cfg_bit` is the cache bit at address k. The cache returns data one cycle after `cache_rd_en`.
- R4: `set_ack` is a one-cycle pulse in the cycle right after the last `cfg_en` cycle. `set_busy` stays high through the acknowledge cycle and is low on the cycle after it.
- R5: A `set_req` that arrives while a load is running is ignored. The running load completes with its original index and bit count, and only one acknowledge is given.
- R6: A compute request accepted while idle with a valid configuration drives `pad_in[15:0]` = op1 and `pad_in[31:16]` = op2 from the next cycle. The pads hold those values until write-back.
- R7: `exec_done` rises on the (LAT+1)-th clock edge after the edge that accepts the compute request. LAT is the latency register, which resets to DEF_LAT and is written by `lat_wr` while idle. `exec_done` stays high until write-back.
- R8: A `store_req` while `exec_done` is high loads `res_out` with `pad_out` on that edge, pulses `res_valid` for one cycle, and drops `exec_done`.
- R9: A compute request with no valid configuration (after reset, or before any completed load) gives a one-cycle `exec_err` pulse on the next cycle. In that case `res_out` is 0 and `exec_done` never rises.
- R10: A `store_req` while `exec_done` is low is ignored: `res_valid` stays low and `res_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 1 | Configure request from the core |
| set_idx | input | IDX_W | Configuration number to load |
| set_busy | output | 1 | Load in progress; further configure requests are refused |
| set_ack | output | 1 | One-cycle pulse when the load has finished |
| lat_wr | input | 1 | Write strobe for the compute latency register |
| lat_val | input | LAT_W | New compute latency in cycles |
| exec_req | input | 1 | Compute request from the core |
| op1 | input | W | First operand register |
| op2 | input | W | Second operand register |
| exec_done | output | 1 | Compute finished; result may be stored |
| exec_err | output | 1 | One-cycle pulse: compute requested with no configuration |
| store_req | input | 1 | Write-back request from the core |
| res_out | output | W | Result register |
| res_valid | output | 1 | One-cycle pulse when `res_out` is updated by write-back |
| cache_rd_en | output | 1 | Configuration cache read strobe |
| cache_idx | output | IDX_W | Configuration number being read |
| cache_addr | output | ADDR_W | Bit address within the bitstream |
| cache_bit | input | 1 | Bitstream bit, valid one cycle after the read |
| cfg_en | output | 1 | Array configuration shift enable |
| cfg_bit | output | 1 | Array serial configuration data |
| pad_in | output | 2*W | Array input pads (op1 low, op2 high) |
| pad_out | input | W | Array output pads |

## Verification
Each result has a fixed delay from its stimulus.
- Busy and the first cache read appear one edge after a configure request is accepted.
- The acknowledge comes BS_LEN+3 edges after the request: one edge for the cache read, one for the output register, and one to detect the end.
- The pads load one edge after a compute request. Done follows LAT+1 edges after that.
- The result and its valid pulse appear one edge after write-back.

The bench drives inputs and samples outputs 1 ns after each rising edge. It counts edges from the accepting edge and compares the observed edge number with the figure above. A model of the array captures the shifted bits and computes its outputs from them. Loaded contents and results are therefore checked against values the bench derives from the configuration number and the operands.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EXEC = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/rfu_bitstream_loader.sv
module rfu_bitstream_loader #(
  parameter int IDX_W  = 4,
  parameter int BS_LEN = 32,
  localparam int ADDR_W = (BS_LEN > 1) ? $clog2(BS_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_bit,
  output logic              cfg_en,
  output logic              cfg_bit,
  output logic              finished
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BS_LEN - 1);

  logic rd_d1;

  // read address generator: one cache address per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      rd_addr <= '0;
      rd_idx  <= '0;
    end else if (start && !rd_en) begin
      rd_en   <= 1'b1;
      rd_addr <= '0;
      rd_idx  <= idx;
    end else if (rd_en) begin
      if (rd_addr == LAST_ADDR) begin
        rd_en <= 1'b0;
      end else begin
        rd_addr <= rd_addr + 1'b1;
      end
    end
  end

  // cache data arrives one cycle after the read; retime it onto the array
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d1    <= 1'b0;
      cfg_en   <= 1'b0;
      cfg_bit  <= 1'b0;
      finished <= 1'b0;
    end else begin
      rd_d1    <= rd_en;
      cfg_en   <= rd_d1;
      cfg_bit  <= rd_d1 ? rd_bit : 1'b0;
      finished <= cfg_en && !rd_d1;
    end
  end
endmodule

// File: rtl/rfu_exec_timer.sv
module rfu_exec_timer #(
  parameter int LAT_W   = 4,
  parameter int DEF_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lat_we,
  input  logic [LAT_W-1:0] lat_val,
  input  logic             start,
  input  logic             clear,
  output logic             done
);
  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= LAT_W'(DEF_LAT);
    end else if (lat_we) begin
      lat_q <= lat_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      done    <= 1'b0;
    end else if (running) begin
      if (cnt == lat_q) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (clear) begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/rfu_pad_adapter.sv
module rfu_pad_adapter #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_ops,
  input  logic [W-1:0]   op1,
  input  logic [W-1:0]   op2,
  input  logic           capture,
  input  logic           zero_res,
  input  logic [W-1:0]   pad_out,
  output logic [2*W-1:0] pad_in,
  output logic [W-1:0]   res
);
  // fixed pad map: first operand on the low pads, second on the high pads
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_in <= '0;
    end else if (load_ops) begin
      pad_in <= {op2, op1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || zero_res) begin
      res <= '0;
    end else if (capture) begin
      res <= pad_out;
    end
  end
endmodule

// File: rtl/rfu_cfg_ctrl.sv
module rfu_cfg_ctrl
  import rfu_pkg::*;
#(
  parameter int W       = 16,
  parameter int IDX_W   = 4,
  parameter int BS_LEN  = 32,
  parameter int LAT_W   = 4,
  parameter int DEF_LAT = 2,
  localparam int ADDR_W = (BS_LEN > 1) ? $clog2(BS_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_req,
  input  logic [IDX_W-1:0]  set_idx,
  output logic              set_busy,
  output logic              set_ack,
  input  logic              lat_wr,
  input  logic [LAT_W-1:0]  lat_val,
  input  logic              exec_req,
  input  logic [W-1:0]      op1,
  input  logic [W-1:0]      op2,
  output logic              exec_done,
  output logic              exec_err,
  input  logic              store_req,
  output logic [W-1:0]      res_out,
  output logic              res_valid,
  output logic              cache_rd_en,
  output logic [IDX_W-1:0]  cache_idx,
  output logic [ADDR_W-1:0] cache_addr,
  input  logic              cache_bit,
  output logic              cfg_en,
  output logic              cfg_bit,
  output logic [2*W-1:0]    pad_in,
  input  logic [W-1:0]      pad_out
);
  ctl_state_e state;
  logic       cfg_valid;
  logic       ld_fin;

  logic in_idle, take_set, take_exec, bad_exec, take_lat, do_store;

  // idle arbitration: configure beats compute beats latency write
  always_comb begin
    in_idle   = (state == ST_IDLE);
    take_set  = in_idle && set_req;
    take_exec = in_idle && !set_req && exec_req && cfg_valid;
    bad_exec  = in_idle && !set_req && exec_req && !cfg_valid;
    take_lat  = in_idle && !set_req && !exec_req && lat_wr;
    do_store  = (state == ST_EXEC) && store_req && exec_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cfg_valid <= 1'b0;
      set_busy  <= 1'b0;
      exec_err  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      exec_err  <= bad_exec;
      res_valid <= do_store;
      unique case (state)
        ST_IDLE: begin
          if (take_set) begin
            state     <= ST_LOAD;
            set_busy  <= 1'b1;
            cfg_valid <= 1'b0;
          end else if (take_exec) begin
            state <= ST_EXEC;
          end
        end
        ST_LOAD: begin
          if (ld_fin) begin
            state     <= ST_IDLE;
            set_busy  <= 1'b0;
            cfg_valid <= 1'b1;
          end
        end
        ST_EXEC: begin
          if (do_store) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign set_ack = ld_fin;

  rfu_bitstream_loader #(.IDX_W(IDX_W), .BS_LEN(BS_LEN)) u_loader (
    .clk      (clk),
    .rst      (rst),
    .start    (take_set),
    .idx      (set_idx),
    .rd_en    (cache_rd_en),
    .rd_idx   (cache_idx),
    .rd_addr  (cache_addr),
    .rd_bit   (cache_bit),
    .cfg_en   (cfg_en),
    .cfg_bit  (cfg_bit),
    .finished (ld_fin)
  );

  rfu_exec_timer #(.LAT_W(LAT_W), .DEF_LAT(DEF_LAT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .lat_we  (take_lat),
    .lat_val (lat_val),
    .start   (take_exec),
    .clear   (do_store),
    .done    (exec_done)
  );

  rfu_pad_adapter #(.W(W)) u_adapter (
    .clk      (clk),
    .rst      (rst),
    .load_ops (take_exec),
    .op1      (op1),
    .op2      (op2),
    .capture  (do_store),
    .zero_res (bad_exec),
    .pad_out  (pad_out),
    .pad_in   (pad_in),
    .res      (res_out)
  );
endmodule

// File: rtl/rfu_cfg_ctrl_chk.sv
module rfu_cfg_ctrl_chk #(
  parameter int W      = 16,
  parameter int BS_LEN = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           set_busy,
  input logic           set_ack,
  input logic           cfg_en,
  input logic           exec_done,
  input logic           exec_err,
  input logic           res_valid,
  input logic [W-1:0]   res_out,
  input logic [2*W-1:0] pad_in
);
  localparam int CW = $clog2(BS_LEN + 1) + 1;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else     run_cnt <= cfg_en ? run_cnt + 1'b1 : '0;
  end

  // R3: enable run never exceeds, and ends at, the bitstream length
  a_r3_run_bound: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (run_cnt < CW'(BS_LEN)));
  a_r3_run_len: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_en) |-> (run_cnt == CW'(BS_LEN)));
  // R2: shifting happens only inside a busy window
  a_r2_shift_busy: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> set_busy);
  // R4: acknowledge follows the last enable, inside busy, then busy drops
  a_r4_ack_after_shift: assert property (@(posedge clk) disable iff (rst)
    set_ack |-> $fell(cfg_en));
  a_r4_busy_at_ack: assert property (@(posedge clk) disable iff (rst)
    set_ack |-> set_busy);
  a_r4_busy_release: assert property (@(posedge clk) disable iff (rst)
    set_ack |=> (!set_busy && !set_ack));
  // R6: pads hold while the result waits for write-back
  a_r6_pads_hold: assert property (@(posedge clk) disable iff (rst)
    (exec_done && $past(exec_done)) |-> $stable(pad_in));
  // R8: valid pulse only after done, and done is gone with it
  a_r8_valid_after_done: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(exec_done) && !exec_done));
  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R9: error reports a zero result and no done
  a_r9_err_zero: assert property (@(posedge clk) disable iff (rst)
    exec_err |-> (res_out == '0 && !exec_done));
endmodule

bind rfu_cfg_ctrl rfu_cfg_ctrl_chk #(.W(W), .BS_LEN(BS_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .set_busy  (set_busy),
  .set_ack   (set_ack),
  .cfg_en    (cfg_en),
  .exec_done (exec_done),
  .exec_err  (exec_err),
  .res_valid (res_valid),
  .res_out   (res_out),
  .pad_in    (pad_in)
);

// File: tb/sim_rfu_cfg_ctrl.sv
`timescale 1ns/1ps
module sim_rfu_cfg_ctrl;
  localparam int W  = 16;
  localparam int IW = 4;
  localparam int L  = 32;
  localparam int LW = 4;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          set_req = 1'b0;
  logic [IW-1:0] set_idx = '0;
  logic          set_busy, set_ack;
  logic          lat_wr = 1'b0;
  logic [LW-1:0] lat_val = '0;
  logic          exec_req = 1'b0;
  logic [W-1:0]  op1 = '0, op2 = '0;
  logic          exec_done, exec_err;
  logic          store_req = 1'b0;
  logic [W-1:0]  res_out;
  logic          res_valid;
  logic          cache_rd_en;
  logic [IW-1:0] cache_idx;
  logic [AW-1:0] cache_addr;
  logic          cache_bit;
  logic          cfg_en, cfg_bit;
  logic [2*W-1:0] pad_in;
  logic [W-1:0]  pad_out;

  rfu_cfg_ctrl #(.W(W), .IDX_W(IW), .BS_LEN(L), .LAT_W(LW), .DEF_LAT(2)) u0 (
    .clk(clk), .rst(rst), .set_req(set_req), .set_idx(set_idx),
    .set_busy(set_busy), .set_ack(set_ack), .lat_wr(lat_wr), .lat_val(lat_val),
    .exec_req(exec_req), .op1(op1), .op2(op2), .exec_done(exec_done),
    .exec_err(exec_err), .store_req(store_req), .res_out(res_out),
    .res_valid(res_valid), .cache_rd_en(cache_rd_en), .cache_idx(cache_idx),
    .cache_addr(cache_addr), .cache_bit(cache_bit), .cfg_en(cfg_en),
    .cfg_bit(cfg_bit), .pad_in(pad_in), .pad_out(pad_out)
  );

  always #2.5 clk = ~clk;

  function automatic logic pat(input logic [IW-1:0] idx, input logic [AW-1:0] a);
    logic [7:0] h;
    h = {idx, 4'h0} ^ {3'b0, a} ^ 8'(a * 7) ^ 8'(idx * 13);
    return ^(h & 8'h6D);
  endfunction

  function automatic logic [L-1:0] exp_cfg(input logic [IW-1:0] idx);
    logic [L-1:0] w;
    w = '0;
    for (int k = 0; k < L; k++) w = {w[L-2:0], pat(idx, AW'(k))};
    return w;
  endfunction

  // cache model: one-cycle read latency
  always @(posedge clk) if (cache_rd_en) cache_bit <= pat(cache_idx, cache_addr);

  // array model and monitors
  logic [L-1:0]  cfg_sr = '0;
  int            cfg_cnt = 0, ack_cnt = 0;
  logic          mon_clr = 1'b0, rd_bad = 1'b0;
  logic [AW-1:0] addr_exp = '0;
  logic [IW-1:0] idx_exp = '0;
  always @(posedge clk) begin
    if (mon_clr) begin
      cfg_cnt <= 0; ack_cnt <= 0; rd_bad <= 1'b0; addr_exp <= '0;
    end else begin
      if (cfg_en) begin cfg_sr <= {cfg_sr[L-2:0], cfg_bit}; cfg_cnt <= cfg_cnt + 1; end
      if (set_ack) ack_cnt <= ack_cnt + 1;
      if (cache_rd_en) begin
        if (cache_addr != addr_exp || cache_idx != idx_exp) rd_bad <= 1'b1;
        addr_exp <= addr_exp + 1'b1;
      end
    end
  end
  assign pad_out = (pad_in[W-1:0] + pad_in[2*W-1:W]) ^ cfg_sr[W-1:0];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_mon(input logic [IW-1:0] idx);
    idx_exp = idx; mon_clr = 1'b1; tick(); mon_clr = 1'b0;
  endtask

  task automatic wait_ack(output int edges);
    edges = 0;
    while (!set_ack && edges < 200) begin tick(); edges++; end
  endtask

  task automatic load_cfg(input logic [IW-1:0] idx);
    int e;
    clear_mon(idx);
    set_req = 1'b1; set_idx = idx; tick(); set_req = 1'b0;
    chk("R2 busy after set", set_busy, 1);
    chk("R2 first read", {cache_rd_en, 8'(cache_addr)}, {1'b1, 8'h00});
    wait_ack(e);
    chk("R4 ack edge", e + 1, L + 3);
    chk("R4 busy at ack", set_busy, 1);
    chk("R3 enable count", cfg_cnt, L);
    chk("R3 loaded bits", cfg_sr, exp_cfg(idx));
    chk("R2 read sequence", rd_bad, 0);
    tick();
    chk("R4 busy after ack", {set_busy, set_ack}, 2'b00);
  endtask

  task automatic set_lat(input logic [LW-1:0] v);
    lat_wr = 1'b1; lat_val = v; tick(); lat_wr = 1'b0;
  endtask

  task automatic run_exec(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int lat, input logic [W-1:0] expect_res);
    int m;
    op1 = a; op2 = b; exec_req = 1'b1; tick(); exec_req = 1'b0;
    chk("R6 pads", pad_in, {b, a});
    m = 0;
    while (!exec_done && m < 100) begin tick(); m++; end
    chk("R7 done edge", m, lat + 1);
    op1 = ~a; tick();
    chk("R7 done held", exec_done, 1);
    chk("R6 pads held", pad_in, {b, a});
    store_req = 1'b1; tick(); store_req = 1'b0;
    chk("R8 store", {res_valid, exec_done, res_out}, {1'b1, 1'b0, expect_res});
    tick();
    chk("R8 valid pulse", res_valid, 0);
  endtask

  // stimulus vectors: {index, latency, op1, op2}
  localparam logic [39:0] VEC [0:3] = '{
    {4'h3, 4'h0, 16'h1234, 16'h0F0F},
    {4'hA, 4'h2, 16'hFFFF, 16'h0001},
    {4'h0, 4'hF, 16'h8000, 16'h8000},
    {4'h5, 4'h1, 16'h00FF, 16'hFF00}
  };

  initial begin
    logic [W-1:0] keep;
    int e;
    repeat (3) tick();
    rst = 1'b0;
    // R1: reset state
    chk("R1 outputs", {set_busy, set_ack, cfg_en, exec_done, exec_err, res_valid, res_out},
        {6'b0, 16'h0});
    // R9: compute before any configuration
    exec_req = 1'b1; op1 = 16'h1111; op2 = 16'h2222; tick(); exec_req = 1'b0;
    chk("R9 err pulse", {exec_err, res_out}, {1'b1, 16'h0});
    tick();
    chk("R9 no done", {exec_err, exec_done}, 2'b00);

    for (int i = 0; i < 4; i++) begin
      logic [IW-1:0] vi; logic [LW-1:0] vl; logic [W-1:0] va, vb;
      {vi, vl, va, vb} = VEC[i];
      load_cfg(vi);
      set_lat(vl);
      run_exec(va, vb, int'(vl), (va + vb) ^ exp_cfg(vi)[W-1:0]);
    end

    // R10: store with nothing pending
    keep = res_out;
    store_req = 1'b1; tick(); store_req = 1'b0;
    chk("R10 idle store", {res_valid, res_out}, {1'b0, keep});
    // R10: store before done arrives (latency 15)
    set_lat(4'hF);
    op1 = 16'h0101; op2 = 16'h0202; exec_req = 1'b1; tick(); exec_req = 1'b0;
    store_req = 1'b1; tick(); store_req = 1'b0;
    chk("R10 early store", {res_valid, exec_done, res_out}, {2'b00, keep});
    e = 0;
    while (!exec_done && e < 100) begin tick(); e++; end
    chk("R10 done still comes", e, 15);
    store_req = 1'b1; tick(); store_req = 1'b0;
    chk("R8 late store", res_out, 16'h0303 ^ exp_cfg(4'h5)[W-1:0]);

    // R5: configure request during a load is turned away
    clear_mon(4'h9);
    set_req = 1'b1; set_idx = 4'h9; tick(); set_req = 1'b0;
    repeat (4) tick();
    set_req = 1'b1; set_idx = 4'h6; tick(); set_req = 1'b0;
    wait_ack(e);
    chk("R5 ack edge", e + 6, L + 3);
    chk("R5 original bits", cfg_sr, exp_cfg(4'h9));
    chk("R5 count", cfg_cnt, L);
    repeat (40) tick();
    chk("R5 single ack", {ack_cnt, 1'b0, set_busy}, {32'd1, 2'b00});

    // R9: reset drops the configuration
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 after rerun reset", {set_busy, exec_done, res_out}, {2'b00, 16'h0});
    exec_req = 1'b1; tick(); exec_req = 1'b0;
    chk("R9 err after reset", {exec_err, res_out}, {1'b1, 16'h0});
    tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule